// File: doc/BRIEF.md
# Keyboard/Mouse Port Register Front-End

This block is the software-visible face of a keyboard or mouse serial port. A host on a simple word-addressed peripheral bus (select, write flag, byte address, write data, combinational read data) reaches five registers: a control word, a status word, a receive/transmit data port, a clock-divisor word and an interrupt-status word. A read-only window at the top of the 4 KiB region returns eight fixed identification bytes. The serial line itself, its clock division and its parity live in a neighbouring receiver and transmitter. The receiver hands bytes in over a valid/ready stream. The transmitter takes bytes as a byte plus a one-cycle strobe.

The receive side holds no queue. A byte counts as pending for as long as the receiver keeps it valid. A data-port read takes the byte and copies it into a last-byte register. A data-port read with nothing pending returns that last byte again. The interrupt output combines a gated receive condition with a transmit condition that is always ready. Setting the transmit enable therefore raises the interrupt on its own.

Top module: `kbd_mouse_regs`

## Requirements
- R1: The control word (word offset 0, byte address 0x000) and the clock-divisor word (word offset 3, byte address 0x00C) store all 32 written bits. A read returns them from the cycle after the write.
- R2: Reads at byte addresses 0xFE0 to 0xFFF return one identification byte, zero-extended, chosen by (address−0xFE0)/4. The bytes for indices 0 to 7 are 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R3: A status read (word offset 1) returns 0x10 while a received byte is pending and 0 when none is.
- R4: An interrupt-status read (word offset 4) returns 2 + pending: bit 1 is always 1 and bit 0 is the pending flag.
- R5: irq equals (pending AND control bit 4) OR control bit 3. The effect of a control write shows from the cycle after that write.
- R6: A data-port read (word offset 2) while a byte is pending returns that byte, asserts rx_ready in the same cycle, and loads the byte into the last-byte register.
- R7: A data-port read with nothing pending returns the last-byte register unchanged.
- R8: A data-port write raises tx_strobe for exactly one cycle, the cycle after the write, with tx_byte equal to the low 8 written bits. No other access raises tx_strobe.
- R9: Writes to the status, interrupt-status, identification and undefined addresses change no register. Reads of undefined addresses return 0.
- R10: rx_ready is high only during a data-port read. A pending byte stays pending through all other accesses.
- R11: After reset the control word, clock divisor and last byte read 0 and irq is low when no byte is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Receiver offers a byte |
| rx_byte | input | 8 | Offered byte |
| rx_ready | output | 1 | Byte taken at this edge |
| tx_strobe | output | 1 | One-cycle send request |
| tx_byte | output | 8 | Byte to send |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume the receiver follows the valid/ready rule: rx_byte stays fixed while rx_valid is high, and rx_valid drops only after a transfer. They also assume bus inputs change only between clock edges. The bench drives all inputs on the falling edge. It offers a new random byte only when the previous one has been taken, and removes a byte in the cycle after its read. Random accesses mix defined, identification and undefined addresses so that the ignored-write and zero-read cases arise next to the normal ones.

// File: rtl/kmr_pkg.sv
package kmr_pkg;
  localparam int unsigned WORD_CTRL   = 0;
  localparam int unsigned WORD_STAT   = 1;
  localparam int unsigned WORD_DATA   = 2;
  localparam int unsigned WORD_CLKDIV = 3;
  localparam int unsigned WORD_ISTAT  = 4;

  localparam int unsigned ID_BASE  = 32'hFE0;
  localparam int unsigned ID_BYTES = 32;

  localparam int unsigned STAT_PEND_BIT = 4;
  localparam int unsigned CTRL_TXIE_BIT = 3;
  localparam int unsigned CTRL_RXIE_BIT = 4;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_STAT, SEL_DATA, SEL_CLKDIV, SEL_ISTAT, SEL_ID
  } reg_sel_e;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = 8'h50;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/kmr_rst_sync.sv
module kmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/kmr_ctrl_regs.sv
module kmr_ctrl_regs
  import kmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              we_ctrl,
  input  logic              we_clkdiv,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pending,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] clkdiv_q,
  output logic              irq
);
  logic [DATA_W-1:0] ctrl_d;
  logic [DATA_W-1:0] clkdiv_d;

  always_comb begin
    ctrl_d   = ctrl_q;
    clkdiv_d = clkdiv_q;
    if (we_ctrl)   ctrl_d   = wdata;
    if (we_clkdiv) clkdiv_d = wdata;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q   <= '0;
      clkdiv_q <= '0;
    end else begin
      if (we_ctrl)   ctrl_q   <= ctrl_d;
      if (we_clkdiv) clkdiv_q <= clkdiv_d;
    end
  end

  always_comb begin
    irq = (pending && ctrl_q[CTRL_RXIE_BIT]) || ctrl_q[CTRL_TXIE_BIT];
  end

  p_ctrl_store_r1: assert property (@(posedge clk) disable iff (!srst_n)
    we_ctrl |=> ctrl_q == $past(wdata));
  p_clkdiv_store_r1: assert property (@(posedge clk) disable iff (!srst_n)
    we_clkdiv |=> clkdiv_q == $past(wdata));
  p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !we_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/kmr_rx_hold.sv
module kmr_rx_hold #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              rd_data,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic [BYTE_W-1:0] data_out
);
  logic [BYTE_W-1:0] last_q;
  logic [BYTE_W-1:0] last_d;
  logic              take;

  always_comb begin
    rx_ready = rd_data;
    take     = rd_data && rx_valid;
    last_d   = take ? rx_byte : last_q;
    data_out = last_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)   last_q <= '0;
    else if (take) last_q <= last_d;
  end

  p_take_loads_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (rx_ready && rx_valid) |=> last_q == $past(rx_byte));
  p_empty_read_keeps_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_data && !rx_valid) |=> $stable(last_q));
endmodule

// File: rtl/kmr_tx_port.sv
module kmr_tx_port #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              we_data,
  input  logic [BYTE_W-1:0] wbyte,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte
);
  logic              stb_d;
  logic [BYTE_W-1:0] byte_d;

  always_comb begin
    stb_d  = we_data;
    byte_d = we_data ? wbyte : tx_byte;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else begin
      tx_strobe <= stb_d;
      if (we_data) tx_byte <= byte_d;
    end
  end

  p_tx_pulse_r8: assert property (@(posedge clk) disable iff (!srst_n)
    we_data |=> (tx_strobe && tx_byte == $past(wbyte)));
  p_tx_quiet_r8: assert property (@(posedge clk) disable iff (!srst_n)
    !we_data |=> !tx_strobe);
endmodule

// File: rtl/kbd_mouse_regs.sv
module kbd_mouse_regs
  import kmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic              srst_n;
  logic [WORD_W-1:0] word_idx;
  logic [2:0]        id_idx;
  reg_sel_e          sel;
  logic              rd_data, we_ctrl, we_clkdiv, we_data;
  logic [DATA_W-1:0] ctrl_q, clkdiv_q;
  logic [BYTE_W-1:0] data_out;

  kmr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  always_comb begin
    word_idx = bus_addr[ADDR_W-1:2];
    id_idx   = bus_addr[4:2];
    sel      = SEL_NONE;
    if (32'(bus_addr) >= ID_BASE && 32'(bus_addr) < ID_BASE + ID_BYTES)
      sel = SEL_ID;
    else if (32'(word_idx) == WORD_CTRL)   sel = SEL_CTRL;
    else if (32'(word_idx) == WORD_STAT)   sel = SEL_STAT;
    else if (32'(word_idx) == WORD_DATA)   sel = SEL_DATA;
    else if (32'(word_idx) == WORD_CLKDIV) sel = SEL_CLKDIV;
    else if (32'(word_idx) == WORD_ISTAT)  sel = SEL_ISTAT;
  end

  always_comb begin
    rd_data   = bus_sel && !bus_wr && (sel == SEL_DATA);
    we_ctrl   = bus_sel &&  bus_wr && (sel == SEL_CTRL);
    we_clkdiv = bus_sel &&  bus_wr && (sel == SEL_CLKDIV);
    we_data   = bus_sel &&  bus_wr && (sel == SEL_DATA);
  end

  kmr_ctrl_regs #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .srst_n(srst_n), .we_ctrl(we_ctrl), .we_clkdiv(we_clkdiv),
    .wdata(bus_wdata), .pending(rx_valid), .ctrl_q(ctrl_q),
    .clkdiv_q(clkdiv_q), .irq(irq)
  );

  kmr_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .srst_n(srst_n), .rd_data(rd_data), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_ready(rx_ready), .data_out(data_out)
  );

  kmr_tx_port #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .srst_n(srst_n), .we_data(we_data),
    .wbyte(bus_wdata[BYTE_W-1:0]), .tx_strobe(tx_strobe), .tx_byte(tx_byte)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (sel)
        SEL_CTRL:   bus_rdata = ctrl_q;
        SEL_STAT:   bus_rdata[STAT_PEND_BIT] = rx_valid;
        SEL_DATA:   bus_rdata = DATA_W'(data_out);
        SEL_CLKDIV: bus_rdata = clkdiv_q;
        SEL_ISTAT:  bus_rdata = DATA_W'({1'b1, rx_valid});
        SEL_ID:     bus_rdata = DATA_W'(id_byte(id_idx));
        default:    bus_rdata = '0;
      endcase
    end
  end

  p_ready_on_read_r10: assert property (@(posedge clk) disable iff (!srst_n)
    rx_ready |-> (bus_sel && !bus_wr));
  p_txie_irq_r5: assert property (@(posedge clk) disable iff (!srst_n)
    ctrl_q[CTRL_TXIE_BIT] |-> irq);
  p_no_irq_idle_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (!rx_valid && !ctrl_q[CTRL_TXIE_BIT]) |-> !irq);
endmodule

// File: tb/test_kbd_mouse_regs.sv
module test_kbd_mouse_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_ready, tx_strobe, irq;
  logic [7:0]  tx_byte;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] m_ctrl = 0, m_clkdiv = 0;
  logic [7:0]  m_last = 0;

  always #4 clk = ~clk;

  kbd_mouse_regs i_kbd_mouse_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
  );

  function automatic logic [7:0] ref_id(input int i);
    logic [7:0] t [8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[i];
  endfunction

  function automatic logic [31:0] ref_read(input logic [11:0] a);
    if (a >= 12'hFE0) return {24'd0, ref_id(int'((a - 12'hFE0) >> 2))};
    case (a >> 2)
      12'd0: return m_ctrl;
      12'd1: return rx_valid ? 32'h10 : 32'h0;
      12'd2: return {24'd0, rx_valid ? rx_byte : m_last};
      12'd3: return m_clkdiv;
      12'd4: return {30'd0, 1'b1, rx_valid};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic ref_irq();
    return (rx_valid && m_ctrl[4]) || m_ctrl[3];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [11:0] a);
    if (a >= 12'hFE0) return "R2";
    case (a >> 2)
      12'd0, 12'd3: return "R1";
      12'd1: return "R3";
      12'd2: return rx_valid ? "R6" : "R7";
      12'd4: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic do_read(input logic [11:0] a);
    logic [31:0] exp;
    logic popped;
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    exp = ref_read(a);
    check(req_of(a), bus_rdata, exp);
    check("R10", {31'd0, rx_ready}, {31'd0, (a >> 2) == 12'd2 && a < 12'hFE0});
    popped = rx_ready && rx_valid;
    if ((a >> 2) == 12'd2 && a < 12'hFE0) m_last = exp[7:0];
    @(negedge clk);
    bus_sel = 0;
    if (popped) rx_valid = 0;
    #1;
    check("R8", {31'd0, tx_strobe}, 32'd0);
    check("R5", {31'd0, irq}, {31'd0, ref_irq()});
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    #1;
    check("R10", {31'd0, rx_ready}, 32'd0);
    if (a < 12'hFE0 && (a >> 2) == 12'd0) m_ctrl = d;
    if (a < 12'hFE0 && (a >> 2) == 12'd3) m_clkdiv = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    #1;
    if (a < 12'hFE0 && (a >> 2) == 12'd2) begin
      check("R8", {31'd0, tx_strobe}, 32'd1);
      check("R8", {24'd0, tx_byte}, {24'd0, d[7:0]});
    end else begin
      check("R8", {31'd0, tx_strobe}, 32'd0);
    end
    check("R5", {31'd0, irq}, {31'd0, ref_irq()});
  endtask

  task automatic offer(input logic [7:0] b);
    rx_byte = b; rx_valid = 1;
    #1;
  endtask

  function automatic logic [11:0] pick_addr(input int r);
    case (r % 10)
      0: return 12'h000;
      1: return 12'h004;
      2, 3: return 12'h008;
      4: return 12'h00C;
      5: return 12'h010;
      6: return 12'h014;
      7: return 12'h400;
      default: return 12'hFE0 + 12'(4 * (r % 8));
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    // R11: reset state
    check("R11", {31'd0, irq}, 32'd0);
    check("R11", {31'd0, tx_strobe}, 32'd0);
    @(negedge clk);
    do_read(12'h000);
    do_read(12'h00C);
    do_read(12'h008);
    do_read(12'h004);
    do_read(12'h010);
    // R2: whole identification window
    for (int i = 0; i < 8; i++) do_read(12'hFE0 + 12'(4 * i));
    // R1: full width
    do_write(12'h000, 32'hFFFF_FFE7); do_read(12'h000);
    do_write(12'h00C, 32'hA5C3_0F1E); do_read(12'h00C);
    // R5: transmit enable alone drives irq
    do_write(12'h000, 32'h8); do_read(12'h004);
    do_write(12'h000, 32'h10);
    offer(8'h3C);
    check("R5", {31'd0, irq}, 32'd1);
    // R10: other accesses leave the byte pending
    do_read(12'h004); do_read(12'h010); do_write(12'h004, 32'hFF);
    check("R10", {31'd0, rx_valid}, 32'd1);
    do_read(12'h008);            // R6 pop
    do_read(12'h008);            // R7 repeat
    do_read(12'h004);
    // R9: ignored writes
    do_write(12'h010, 32'h1234); do_write(12'hFE4, 32'h55);
    do_write(12'h200, 32'hDEAD); do_read(12'h000); do_read(12'h00C);
    do_read(12'h200);
    // R8: back-to-back sends
    do_write(12'h008, 32'h1AB); do_write(12'h008, 32'h0CD);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom % 1000);
      if (!rx_valid && (r % 3) == 0) offer(8'($urandom));
      if ((r % 5) < 3) do_read(pick_addr(int'($urandom)));
      else do_write(pick_addr(int'($urandom)), $urandom);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule